// File: doc/BRIEF.md
# Sparse Row-Wise Partial-Sum Accumulator

This unit sits behind a processing-element array that performs one-dimensional row convolutions on pruned kernels. The kernel stream keeps only the non-zero kernel rows, and each row is tagged with a filter identifier (FID). Every cycle, each input lane may present one partial-sum row. The row carries its FID, an output-row index, a column offset, a first-pass bit and a vector of `NV` psum values. Psums are summed here, outside the processing elements.

Every output channel owns a fixed, contiguous region of the accumulation memory. The word address is `fid*cfg_blk_size + row*cfg_row_len + col`, kept to `AW` bits. Each accepted row goes through two steps. In the first step the stored word is read, with forwarding from the write step. In the second step the row is added to it (or replaces it on a first pass) and the result is written back.

Padding rows, marked with an empty flag, are consumed and do nothing. Two live lanes that name the same FID in one cycle are a scheduling fault. The lowest lane wins, the others are held off through `in_ready`, and a sticky flag records the fault.

When `layer_done` is seen, a two-state sequencer dumps the region contents in ascending FID order. The states are `ST_ACCUM` (accepting rows) and `ST_DRAIN` (dumping words). The transition `ST_ACCUM -> ST_DRAIN` happens on `layer_done` when both `cfg_num_fid` and `cfg_blk_size` are non-zero. The transition `ST_DRAIN -> ST_ACCUM` happens on the edge that emits the final word.

Top module: `sracc_unit`

## Requirements
- R1: An accepted row updates the word at address `fid*cfg_blk_size + row*cfg_row_len + col`, modulo 2^AW.
- R2: With `in_first` set, the stored word becomes the psum vector itself. Otherwise each of the NV lanes of the word (lane e at bits e*DW upward) becomes the old value plus the psum, modulo 2^DW.
- R3: Updates to the same address in back-to-back cycles, from the same lane or from different lanes, are all retained.
- R4: A valid row with `in_empty` set sees `in_ready` high in `ST_ACCUM`, performs no memory write and leaves every stored word unchanged.
- R5: When two or more valid, non-empty lanes carry the same FID, only the lowest-numbered of them has `in_ready` high. The others are accepted on a later cycle once they no longer clash.
- R6: `conflict_err` is 0 after reset, rises on the edge after a cycle with an R5 clash, and stays 1 until reset.
- R7: Valid non-empty lanes with pairwise distinct FIDs are all accepted in the same cycle. A lane with `in_valid` low sees `in_ready` high in `ST_ACCUM`.
- R8: After `layer_done` is sampled in `ST_ACCUM`, the first word appears one cycle later. From then on, `drn_valid` delivers one word per cycle for FID 0 up to `cfg_num_fid-1`, and for each FID offsets 0 up to `cfg_blk_size-1`. `drn_last` marks the final word, `drn_valid` drops in the cycle after it, and `in_ready` is 0 throughout `ST_DRAIN`.
- R9: After reset: `drn_valid`=0, `drn_last`=0, `conflict_err`=0, state `ST_ACCUM`, and `in_ready` is all ones while no lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blk_size | input | AW | Words per output-channel region |
| cfg_row_len | input | AW | Words per output row inside a region |
| cfg_num_fid | input | FIDW+1 | Number of regions dumped on drain |
| in_valid | input | LANES | Lane carries a row |
| in_empty | input | LANES | Row is padding |
| in_first | input | LANES | First-pass write, no add |
| in_fid | input | LANES*FIDW | Filter identifier per lane |
| in_row | input | LANES*ROWW | Output-row index per lane |
| in_col | input | LANES*COLW | Column offset per lane |
| in_psum | input | LANES*NV*DW | Psum vector per lane |
| in_ready | output | LANES | Row accepted this cycle |
| conflict_err | output | 1 | Sticky same-region clash flag |
| layer_done | input | 1 | Start the dump |
| drn_valid | output | 1 | Dump word valid |
| drn_last | output | 1 | Final dump word |
| drn_fid | output | FIDW | Region of the dump word |
| drn_offset | output | AW | Offset inside the region |
| drn_data | output | NV*DW | Dumped word |

## Verification
The bench keeps the default build: two lanes, two 16-bit psums per word, a 64-word store and 3-bit FIDs. It sets a region size of 8 and a row length of 4, so eight regions tile the whole store exactly. Every address is therefore reachable and is checked in each dump. With two lanes, forwarding can be exercised both from the same lane and across lanes, and the lowest-lane-wins clash rule is visible. Random rows with distinct FIDs in each cycle run beside directed padding, back-to-back and clash cases. Two complete dumps compare every word against a bench model.

// File: rtl/sracc_pkg.sv
package sracc_pkg;
    typedef enum logic [0:0] {
        ST_ACCUM = 1'b0,
        ST_DRAIN = 1'b1
    } sracc_state_t;
endpackage

// File: rtl/sracc_addr_gen.sv
module sracc_addr_gen #(
    parameter int AW   = 6,
    parameter int FIDW = 3,
    parameter int ROWW = 3,
    parameter int COLW = 3
) (
    input  logic [FIDW-1:0] fid,
    input  logic [ROWW-1:0] row,
    input  logic [COLW-1:0] col,
    input  logic [AW-1:0]   blk_size,
    input  logic [AW-1:0]   row_len,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] fid_w, row_w, col_w;

    assign fid_w = AW'(fid);
    assign row_w = AW'(row);
    assign col_w = AW'(col);
    // region base plus row stride plus column, wrapping at 2^AW
    assign addr  = fid_w * blk_size + row_w * row_len + col_w;
endmodule

// File: rtl/sracc_arbiter.sv
module sracc_arbiter #(
    parameter int LANES = 2,
    parameter int FIDW  = 3
) (
    input  logic                  en,
    input  logic [LANES-1:0]      in_valid,
    input  logic [LANES-1:0]      in_empty,
    input  logic [LANES*FIDW-1:0] in_fid,
    output logic [LANES-1:0]      grant,
    output logic [LANES-1:0]      ready,
    output logic                  clash
);
    logic [LANES-1:0] active;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            active[i] = en & in_valid[i] & ~in_empty[i];
        end
        for (int i = 0; i < LANES; i++) begin
            grant[i] = active[i];
            for (int k = 0; k < i; k++) begin
                if (active[k] && (in_fid[k*FIDW +: FIDW] == in_fid[i*FIDW +: FIDW])) begin
                    grant[i] = 1'b0;
                end
            end
            ready[i] = en & (~in_valid[i] | in_empty[i] | grant[i]);
        end
        clash = |(active & ~grant);
    end
endmodule

// File: rtl/sracc_store.sv
module sracc_store #(
    parameter int LANES = 2,
    parameter int NV    = 2,
    parameter int DW    = 16,
    parameter int AW    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         acc_go,
    input  logic [LANES*AW-1:0]      acc_addr,
    input  logic [LANES-1:0]         acc_first,
    input  logic [LANES*NV*DW-1:0]   acc_psum,
    input  logic [AW-1:0]            rd_addr,
    output logic [NV*DW-1:0]         rd_data,
    output logic [LANES-1:0]         wr_en
);
    localparam int DEPTH = 1 << AW;
    localparam int WW    = NV * DW;

    logic [WW-1:0] mem [DEPTH];

    // add-and-write stage registers
    logic [LANES-1:0] w_v;
    logic [LANES-1:0] w_first;
    logic [AW-1:0]    w_addr [LANES];
    logic [WW-1:0]    w_psum [LANES];
    logic [WW-1:0]    w_old  [LANES];
    logic [WW-1:0]    w_sum  [LANES];
    logic [WW-1:0]    r_old  [LANES];

    // write-stage result
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            for (int e = 0; e < NV; e++) begin
                w_sum[j][e*DW +: DW] = w_first[j] ? w_psum[j][e*DW +: DW]
                                                  : w_old[j][e*DW +: DW] + w_psum[j][e*DW +: DW];
            end
        end
    end

    // read stage with forwarding from the write stage
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            r_old[i] = mem[acc_addr[i*AW +: AW]];
            for (int j = 0; j < LANES; j++) begin
                if (w_v[j] && (w_addr[j] == acc_addr[i*AW +: AW])) begin
                    r_old[i] = w_sum[j];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_v <= '0;
        end else begin
            w_v <= acc_go;
        end
    end

    always_ff @(posedge clk) begin
        w_first <= acc_first;
        for (int i = 0; i < LANES; i++) begin
            w_addr[i] <= acc_addr[i*AW +: AW];
            w_psum[i] <= acc_psum[i*WW +: WW];
            w_old[i]  <= r_old[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < LANES; j++) begin
            if (w_v[j]) begin
                mem[w_addr[j]] <= w_sum[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign wr_en   = w_v;
endmodule

// File: rtl/sracc_drain.sv
module sracc_drain #(
    parameter int NV   = 2,
    parameter int DW   = 16,
    parameter int AW   = 6,
    parameter int FIDW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               layer_done,
    input  logic [AW-1:0]      cfg_blk_size,
    input  logic [FIDW:0]      cfg_num_fid,
    input  logic [NV*DW-1:0]   rd_data,
    output logic [AW-1:0]      rd_addr,
    output logic               busy,
    output logic               drn_valid,
    output logic               drn_last,
    output logic [FIDW-1:0]    drn_fid,
    output logic [AW-1:0]      drn_offset,
    output logic [NV*DW-1:0]   drn_data
);
    import sracc_pkg::*;

    sracc_state_t st, st_nx;
    logic [FIDW-1:0] fid_cnt;
    logic [AW-1:0]   off_cnt;
    logic            off_wrap;
    logic            at_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_ACCUM;
        else        st <= st_nx;
    end

    // next state and decoded outputs
    always_comb begin
        off_wrap = (off_cnt == cfg_blk_size - AW'(1));
        at_end   = off_wrap && ({1'b0, fid_cnt} == cfg_num_fid - (FIDW+1)'(1));
        rd_addr  = AW'(fid_cnt) * cfg_blk_size + off_cnt;
        st_nx    = st;
        busy     = 1'b0;
        unique case (st)
            ST_ACCUM: begin
                if (layer_done && (cfg_num_fid != '0) && (cfg_blk_size != '0)) begin
                    st_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                busy = 1'b1;
                if (at_end) st_nx = ST_ACCUM;
            end
            default: st_nx = ST_ACCUM;
        endcase
    end

    // walk counters and dump word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fid_cnt    <= '0;
            off_cnt    <= '0;
            drn_valid  <= 1'b0;
            drn_last   <= 1'b0;
            drn_fid    <= '0;
            drn_offset <= '0;
            drn_data   <= '0;
        end else begin
            drn_valid <= busy;
            drn_last  <= busy & at_end;
            if (busy) begin
                drn_fid    <= fid_cnt;
                drn_offset <= off_cnt;
                drn_data   <= rd_data;
                if (at_end) begin
                    fid_cnt <= '0;
                    off_cnt <= '0;
                end else if (off_wrap) begin
                    fid_cnt <= fid_cnt + FIDW'(1);
                    off_cnt <= '0;
                end else begin
                    off_cnt <= off_cnt + AW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sracc_unit.sv
module sracc_unit #(
    parameter int LANES = 2,
    parameter int NV    = 2,
    parameter int DW    = 16,
    parameter int AW    = 6,
    parameter int FIDW  = 3,
    parameter int ROWW  = 3,
    parameter int COLW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           cfg_blk_size,
    input  logic [AW-1:0]           cfg_row_len,
    input  logic [FIDW:0]           cfg_num_fid,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES-1:0]        in_empty,
    input  logic [LANES-1:0]        in_first,
    input  logic [LANES*FIDW-1:0]   in_fid,
    input  logic [LANES*ROWW-1:0]   in_row,
    input  logic [LANES*COLW-1:0]   in_col,
    input  logic [LANES*NV*DW-1:0]  in_psum,
    output logic [LANES-1:0]        in_ready,
    output logic                    conflict_err,
    input  logic                    layer_done,
    output logic                    drn_valid,
    output logic                    drn_last,
    output logic [FIDW-1:0]         drn_fid,
    output logic [AW-1:0]           drn_offset,
    output logic [NV*DW-1:0]        drn_data
);
    logic [LANES*AW-1:0] lane_addr;
    logic [LANES-1:0]    grant;
    logic [LANES-1:0]    wr_en;
    logic                clash;
    logic                drain_busy;
    logic [AW-1:0]       rd_addr;
    logic [NV*DW-1:0]    rd_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sracc_addr_gen #(.AW(AW), .FIDW(FIDW), .ROWW(ROWW), .COLW(COLW)) u_addr (
            .fid      (in_fid[g*FIDW +: FIDW]),
            .row      (in_row[g*ROWW +: ROWW]),
            .col      (in_col[g*COLW +: COLW]),
            .blk_size (cfg_blk_size),
            .row_len  (cfg_row_len),
            .addr     (lane_addr[g*AW +: AW])
        );
    end

    sracc_arbiter #(.LANES(LANES), .FIDW(FIDW)) u_arb (
        .en       (~drain_busy),
        .in_valid (in_valid),
        .in_empty (in_empty),
        .in_fid   (in_fid),
        .grant    (grant),
        .ready    (in_ready),
        .clash    (clash)
    );

    sracc_store #(.LANES(LANES), .NV(NV), .DW(DW), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_go    (grant),
        .acc_addr  (lane_addr),
        .acc_first (in_first),
        .acc_psum  (in_psum),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en)
    );

    sracc_drain #(.NV(NV), .DW(DW), .AW(AW), .FIDW(FIDW)) u_drain (
        .clk          (clk),
        .rst_n        (rst_n),
        .layer_done   (layer_done),
        .cfg_blk_size (cfg_blk_size),
        .cfg_num_fid  (cfg_num_fid),
        .rd_data      (rd_data),
        .rd_addr      (rd_addr),
        .busy         (drain_busy),
        .drn_valid    (drn_valid),
        .drn_last     (drn_last),
        .drn_fid      (drn_fid),
        .drn_offset   (drn_offset),
        .drn_data     (drn_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     conflict_err <= 1'b0;
        else if (clash) conflict_err <= 1'b1;
    end
endmodule

// File: rtl/sracc_unit_chk.sv
module sracc_unit_chk #(
    parameter int LANES = 2,
    parameter int FIDW  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [LANES-1:0]      in_valid,
    input logic [LANES-1:0]      in_empty,
    input logic [LANES*FIDW-1:0] in_fid,
    input logic [LANES-1:0]      in_ready,
    input logic                  conflict_err,
    input logic [LANES-1:0]      wr_en,
    input logic                  drain_busy,
    input logic                  drn_valid,
    input logic                  drn_last,
    input logic [FIDW-1:0]       drn_fid
);
    // R4: every store write follows an accepted non-empty row
    a_r4_write_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> $past(|(in_valid & ~in_empty & in_ready)));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R4: padding rows are never held off while accumulating
        a_r4_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[g] && in_empty[g] && !drain_busy) |-> in_ready[g]);
    end

    if (LANES > 1) begin : g_pair
        // R5: lane 1 loses against lane 0 on the same FID
        a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[0] && in_valid[1] && !in_empty[0] && !in_empty[1] &&
             (in_fid[0 +: FIDW] == in_fid[FIDW +: FIDW])) |-> !in_ready[1]);
    end

    // R6: the clash flag never clears without reset
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conflict_err) |-> conflict_err);

    // R8: nothing is accepted during a dump
    a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        drain_busy |-> (in_ready == '0));

    // R8: regions leave in ascending FID order
    a_r8_fid_order: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && $past(drn_valid)) |-> (drn_fid >= $past(drn_fid)));

    // R8: the final word ends the stream
    a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drn_last) |-> !drn_valid);
endmodule

bind sracc_unit sracc_unit_chk #(.LANES(LANES), .FIDW(FIDW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_empty     (in_empty),
    .in_fid       (in_fid),
    .in_ready     (in_ready),
    .conflict_err (conflict_err),
    .wr_en        (wr_en),
    .drain_busy   (drain_busy),
    .drn_valid    (drn_valid),
    .drn_last     (drn_last),
    .drn_fid      (drn_fid)
);

// File: tb/sracc_unit_bench.sv
module sracc_unit_bench;
    localparam int L = 2, NV = 2, DW = 16, AW = 6, FIDW = 3, ROWW = 3, COLW = 3;
    localparam int BLK = 8, RLEN = 4, NFID = 8, WORDS = BLK * NFID;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] cfg_blk_size = AW'(BLK), cfg_row_len = AW'(RLEN);
    logic [FIDW:0] cfg_num_fid = (FIDW+1)'(NFID);
    logic [L-1:0] in_valid = '0, in_empty = '0, in_first = '0;
    logic [L*FIDW-1:0] in_fid = '0;
    logic [L*ROWW-1:0] in_row = '0;
    logic [L*COLW-1:0] in_col = '0;
    logic [L*NV*DW-1:0] in_psum = '0;
    logic [L-1:0] in_ready;
    logic conflict_err, layer_done = 1'b0;
    logic drn_valid, drn_last;
    logic [FIDW-1:0] drn_fid;
    logic [AW-1:0] drn_offset;
    logic [NV*DW-1:0] drn_data;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [WORDS][NV];

    always #4 clk = ~clk;

    sracc_unit u_sracc_unit (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int addr_of(int fid, int row, int col);
        return (fid * BLK + row * RLEN + col) % (1 << AW);
    endfunction

    task automatic set_lane(int i, bit v, bit e, bit f, int fid, int row, int col, logic [NV*DW-1:0] d);
        in_valid[i] = v; in_empty[i] = e; in_first[i] = f;
        in_fid[i*FIDW +: FIDW] = FIDW'(fid);
        in_row[i*ROWW +: ROWW] = ROWW'(row);
        in_col[i*COLW +: COLW] = COLW'(col);
        in_psum[i*NV*DW +: NV*DW] = d;
    endtask

    // called just after a falling edge with lanes set; predicts ready and updates the model
    task automatic step();
        logic [L-1:0] act, gnt;
        #1;
        for (int i = 0; i < L; i++) act[i] = in_valid[i] & ~in_empty[i];
        for (int i = 0; i < L; i++) begin
            gnt[i] = act[i];
            for (int k = 0; k < i; k++)
                if (act[k] && in_fid[k*FIDW +: FIDW] == in_fid[i*FIDW +: FIDW]) gnt[i] = 1'b0;
        end
        for (int i = 0; i < L; i++) begin
            if (in_valid[i] && in_empty[i]) chk("R4", "empty lane ready", 64'(in_ready[i]), 64'(1));
            else if (act[i] && !gnt[i])     chk("R5", "loser lane ready", 64'(in_ready[i]), 64'(0));
            else                            chk("R7", "lane ready", 64'(in_ready[i]), 64'(1));
            if (gnt[i] && in_ready[i]) begin
                int a;
                a = addr_of(int'(in_fid[i*FIDW +: FIDW]), int'(in_row[i*ROWW +: ROWW]), int'(in_col[i*COLW +: COLW]));
                for (int e = 0; e < NV; e++) begin
                    logic [DW-1:0] d;
                    d = in_psum[i*NV*DW + e*DW +: DW];
                    model[a][e] = in_first[i] ? d : model[a][e] + d;
                end
            end
        end
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle();
        for (int i = 0; i < L; i++) set_lane(i, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic drain_all();
        idle();
        layer_done = 1'b1;
        @(posedge clk); @(negedge clk);
        layer_done = 1'b0;
        chk("R8", "ready during dump", 64'(in_ready), 64'(0));
        chk("R8", "no word yet", 64'(drn_valid), 64'(0));
        for (int k = 0; k < WORDS; k++) begin
            @(negedge clk);
            chk("R8", "dump valid", 64'(drn_valid), 64'(1));
            chk("R8", "dump fid", 64'(drn_fid), 64'(k / BLK));
            chk("R8", "dump offset", 64'(drn_offset), 64'(k % BLK));
            chk("R8", "dump last", 64'(drn_last), 64'(k == WORDS - 1));
            chk("R1 R2 R3", "dump data", 64'(drn_data), 64'({model[k][1], model[k][0]}));
        end
        @(negedge clk);
        chk("R8", "valid drops after last", 64'(drn_valid), 64'(0));
        chk("R8", "ready back after dump", 64'(in_ready), 64'(3));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset drn_valid", 64'(drn_valid), 64'(0));
        chk("R9", "reset drn_last", 64'(drn_last), 64'(0));
        chk("R9", "reset conflict_err", 64'(conflict_err), 64'(0));
        chk("R9", "reset ready", 64'(in_ready), 64'(3));

        // first-pass fill of every word through lane 0 (R2)
        for (int a = 0; a < WORDS; a++) begin
            idle();
            set_lane(0, 1, 0, 1, a / BLK, (a % BLK) / RLEN, a % RLEN, {16'(a * 3 + 1), 16'(a + 100)});
            step();
        end

        // R3: back-to-back on one address, same lane then cross lane
        idle(); set_lane(0, 1, 0, 0, 2, 1, 3, {16'h0011, 16'h0022}); step();
        set_lane(0, 1, 0, 0, 2, 1, 3, {16'h0100, 16'hFFF0}); step();
        idle(); set_lane(1, 1, 0, 0, 2, 1, 3, {16'h1000, 16'h0005}); step();
        idle(); set_lane(0, 1, 0, 1, 5, 0, 0, {16'hAAAA, 16'h5555}); step();
        set_lane(0, 1, 0, 0, 5, 0, 0, {16'h0001, 16'h0001}); step();

        // R4: padding rows pointing at a live word
        idle(); set_lane(0, 1, 1, 1, 2, 1, 3, {16'hDEAD, 16'hBEEF});
        set_lane(1, 1, 1, 0, 5, 0, 0, {16'h1234, 16'h5678}); step();
        idle(); step();

        // R7 plus random traffic with distinct FIDs per cycle
        for (int n = 0; n < 400; n++) begin
            int f0, f1;
            f0 = int'($urandom % NFID);
            f1 = (f0 + 1 + int'($urandom % (NFID - 1))) % NFID;
            set_lane(0, ($urandom % 10) < 7, ($urandom % 8) == 0, ($urandom % 10) == 0, f0,
                     int'($urandom % 2), int'($urandom % RLEN), NV*DW'($urandom));
            set_lane(1, ($urandom % 10) < 7, ($urandom % 8) == 0, ($urandom % 10) == 0, f1,
                     int'($urandom % 2), int'($urandom % RLEN), NV*DW'($urandom));
            step();
        end
        idle(); step();
        chk("R6", "no clash yet", 64'(conflict_err), 64'(0));
        drain_all();

        // R5/R6: both lanes on FID 3
        idle();
        set_lane(0, 1, 0, 0, 3, 0, 0, {16'h0002, 16'h0003});
        set_lane(1, 1, 0, 0, 3, 1, 1, {16'h0040, 16'h0050});
        step();
        chk("R6", "clash flag raised", 64'(conflict_err), 64'(1));
        set_lane(0, 0, 0, 0, 0, 0, 0, '0);
        step();
        idle(); repeat (3) step();
        chk("R6", "clash flag holds", 64'(conflict_err), 64'(1));
        drain_all();
        chk("R6", "clash flag after dump", 64'(conflict_err), 64'(1));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule